// File: doc/BRIEF.md
# Sixteen-Bit Multi-Mode Tick Timer

This block is a 16-bit counter that advances on a qualified tick. An external tick-enable input passes through a prescaler that divides it by 1, 8, 32 or 128. The counter runs in one of three ways. It can count up freely across the full range. It can count up to a programmable terminal value and then restart at zero. It can count up to the terminal value and back down to zero, which suits centre-aligned pulse-width modulation. A mode value of zero stops the counter, which keeps its value.

Software reaches the timer through a byte-wide register port. Reading the counter's low byte copies the counter's high byte into a holding register in the same cycle. A later read of the high byte returns that copy, so a low-then-high read pair always gives one coherent 16-bit value. Any write to the low byte clears the counter. An overflow event sets a sticky flag. The flag drives an interrupt-pending output through a mask bit, and an interrupt-request output through that mask and a further enable bit.

Top module: `tick_timer16`

## Requirements
- R1: After synchronous reset every register reads 0, the counter is 0x0000, the prescaler phase is 0, and `irq_pend` and `irq_req` are 0.
- R2: The register map is: 0 = control, 1 = counter low byte, 2 = counter high byte (held copy), 3 = terminal low byte, 4 = terminal high byte, 5 = interrupt config (bit 0 mask, bit 1 enable). The control byte holds mode in bits [1:0], divider select in bits [3:2] and the overflow flag in bit 4. A read strobe returns data on `reg_rdata` at the next clock edge.
- R3: Mode 00 halts the counter: it holds its value whatever ticks arrive.
- R4: Divider select 00, 01, 10 and 11 advance the counter once per 1, 8, 32 and 128 ticks respectively.
- R5: Every write to the control register restarts the prescaler phase, so the next counter step comes one full divided period of ticks later.
- R6: Mode 01 (free-running) increments by one per step and wraps from 0xFFFF to 0x0000. The overflow flag sets on the step at which the counter becomes 0xFFFF.
- R7: Mode 10 (modulo) increments up to the terminal value. The flag sets on the step that reaches it, and the next step reloads 0x0000.
- R8: Mode 11 (up/down) counts up to the terminal value, then down to 0x0000. The flag sets on the step that reaches zero, and counting then turns upward again.
- R9: A read of the counter low byte returns the low byte and copies the current high byte into the holding register. A read of address 2 returns that held copy, even if the counter has moved since.
- R10: Any write to the counter low byte clears the counter to 0x0000 and sets the direction to up. The clear wins over a step in the same cycle.
- R11: The overflow flag is sticky. Writing control with bit 4 = 0 clears it. Writing bit 4 = 1 has no effect. A flag-setting step in the same cycle as a clearing write leaves the flag set.
- R12: `irq_pend` equals flag AND mask, and `irq_req` equals flag AND mask AND enable. Both are registered, one cycle after the state that drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Tick enable feeding the prescaler |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_pend | output | 1 | Masked overflow pending |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions take several things for granted. The control register is written only with a divider select that is also present in its own prescaler phase logic. The up/down step property applies only while the terminal value is non-zero. A write and a read are never strobed in the same cycle. The bench drives one strobe at a time, always programs a terminal value of at least 3 before using modulo or up/down modes, and changes the divider only through control writes. Ticks are driven as whole high cycles between falling edges, so every tick count the bench expects is exact.

// File: rtl/tick_timer16_pkg.sv
package tick_timer16_pkg;
  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_FREE = 2'b01,
    MODE_MOD  = 2'b10,
    MODE_UPDN = 2'b11
  } tmr_mode_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] A_CNT_LO = 3'd1;
  localparam logic [REG_AW-1:0] A_CNT_HI = 3'd2;
  localparam logic [REG_AW-1:0] A_TRM_LO = 3'd3;
  localparam logic [REG_AW-1:0] A_TRM_HI = 3'd4;
  localparam logic [REG_AW-1:0] A_IRQCFG = 3'd5;

  localparam int FLAG_BIT = 4;
endpackage

// File: rtl/tick_timer16_prescale.sv
module tick_timer16_prescale #(
  parameter int PRE_W = 7,
  parameter logic [3:0][2:0] SHIFTS = {3'd7, 3'd5, 3'd3, 3'd0}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic       run,
  input  logic [1:0] div_sel,
  input  logic       phase_clr,
  output logic       step
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] limit;
  logic             hit;

  // terminal phase of the selected ratio: 2^shift - 1
  always_comb begin
    limit = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(SHIFTS[div_sel])) limit[i] = 1'b1;
    end
  end

  assign hit  = (phase_q >= limit);
  assign step = run && tick_in && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (phase_clr) begin
      phase_q <= '0;
    end else if (run && tick_in) begin
      phase_q <= hit ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer16_core.sv
module tick_timer16_core
  import tick_timer16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_mode_e        mode,
  input  logic             step,
  input  logic             clr,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic             up_q, up_n;
  logic [CNT_W-1:0] cnt_n;
  logic             evt_n;

  always_comb begin
    cnt_n = cnt;
    up_n  = up_q;
    evt_n = 1'b0;
    if (clr) begin
      cnt_n = '0;
      up_n  = 1'b1;
    end else if (step) begin
      unique case (mode)
        MODE_FREE: begin
          cnt_n = cnt + ONE;
          evt_n = (cnt == FULL - ONE);
        end
        MODE_MOD: begin
          if (cnt >= term) begin
            cnt_n = '0;
          end else begin
            cnt_n = cnt + ONE;
            evt_n = (cnt + ONE == term);
          end
        end
        MODE_UPDN: begin
          if (up_q) begin
            if (cnt < term) begin
              cnt_n = cnt + ONE;
            end else if (cnt <= ONE) begin
              cnt_n = '0;
              evt_n = (cnt == ONE);
            end else begin
              cnt_n = cnt - ONE;
              up_n  = 1'b0;
            end
          end else begin
            if (cnt == '0) begin
              cnt_n = ONE;
              up_n  = 1'b1;
            end else begin
              cnt_n = cnt - ONE;
              if (cnt == ONE) begin
                evt_n = 1'b1;
                up_n  = 1'b1;
              end
            end
          end
        end
        default: cnt_n = cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      up_q <= 1'b1;
    end else begin
      cnt  <= cnt_n;
      up_q <= up_n;
    end
  end

  assign ovf_evt = evt_n;
endmodule

// File: rtl/tick_timer16_regs.sv
module tick_timer16_regs
  import tick_timer16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf_evt,
  output logic [DATA_W-1:0] rdata,
  output tmr_mode_e         mode,
  output logic [1:0]        div_sel,
  output logic [CNT_W-1:0]  term,
  output logic              cnt_clr,
  output logic              phase_clr,
  output logic              flag,
  output logic              irq_pend,
  output logic              irq_req
);
  logic              mask_q, en_q;
  logic [DATA_W-1:0] hold_q;
  logic              flag_n;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_ctrl;

  assign wr_ctrl   = wr && (addr == A_CTRL);
  assign phase_clr = wr_ctrl;
  assign cnt_clr   = wr && (addr == A_CNT_LO);

  // sticky flag: a set event outranks the software clear
  always_comb begin
    flag_n = flag;
    if (wr_ctrl && !wdata[FLAG_BIT]) flag_n = 1'b0;
    if (ovf_evt) flag_n = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_CTRL:   rd_mux = DATA_W'({flag, div_sel, mode});
      A_CNT_LO: rd_mux = cnt[DATA_W-1:0];
      A_CNT_HI: rd_mux = hold_q;
      A_TRM_LO: rd_mux = term[DATA_W-1:0];
      A_TRM_HI: rd_mux = term[CNT_W-1:DATA_W];
      A_IRQCFG: rd_mux = DATA_W'({en_q, mask_q});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_HALT;
      div_sel  <= '0;
      term     <= '0;
      mask_q   <= 1'b0;
      en_q     <= 1'b0;
      hold_q   <= '0;
      flag     <= 1'b0;
      rdata    <= '0;
      irq_pend <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      flag     <= flag_n;
      irq_pend <= flag && mask_q;
      irq_req  <= flag && mask_q && en_q;
      if (wr) begin
        unique case (addr)
          A_CTRL: begin
            mode    <= tmr_mode_e'(wdata[1:0]);
            div_sel <= wdata[3:2];
          end
          A_TRM_LO: term[DATA_W-1:0]     <= wdata;
          A_TRM_HI: term[CNT_W-1:DATA_W] <= wdata;
          A_IRQCFG: begin
            mask_q <= wdata[0];
            en_q   <= wdata[1];
          end
          default: ;
        endcase
      end
      if (rd) begin
        rdata <= rd_mux;
        if (addr == A_CNT_LO) hold_q <= cnt[CNT_W-1:DATA_W];
      end
    end
  end
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
  import tick_timer16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pend,
  output logic              irq_req
);
  localparam int CNT_W = 2 * DATA_W;

  tmr_mode_e        mode_w;
  logic [1:0]       div_w;
  logic [CNT_W-1:0] term_w;
  logic [CNT_W-1:0] cnt_w;
  logic             cnt_clr_w;
  logic             phase_clr_w;
  logic             step_w;
  logic             ovf_evt_w;
  logic             flag_w;

  tick_timer16_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .cnt(cnt_w), .ovf_evt(ovf_evt_w), .rdata(reg_rdata),
    .mode(mode_w), .div_sel(div_w), .term(term_w), .cnt_clr(cnt_clr_w),
    .phase_clr(phase_clr_w), .flag(flag_w), .irq_pend(irq_pend),
    .irq_req(irq_req)
  );

  tick_timer16_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick_in(tick_in), .run(mode_w != MODE_HALT),
    .div_sel(div_w), .phase_clr(phase_clr_w), .step(step_w)
  );

  tick_timer16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .mode(mode_w), .step(step_w), .clr(cnt_clr_w),
    .term(term_w), .cnt(cnt_w), .ovf_evt(ovf_evt_w)
  );
endmodule

// File: rtl/tick_timer16_chk.sv
module tick_timer16_chk
  import tick_timer16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_in,
  input tmr_mode_e        mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] term,
  input logic             cnt_clr,
  input logic             step,
  input logic             ovf_evt,
  input logic             flag,
  input logic             irq_pend,
  input logic             irq_req
);
  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HALT && !cnt_clr) |=> $stable(cnt));
  // R10
  low_write_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (cnt == '0));
  // R4
  step_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> tick_in);
  // R6
  free_increment_chk: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_FREE && !cnt_clr) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R8
  updown_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_UPDN && !cnt_clr && term != '0) |=>
      (cnt == $past(cnt) + CNT_W'(1) || cnt == $past(cnt) - CNT_W'(1)));
  // R11
  flag_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flag);
  // R12
  req_implies_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_pend);
endmodule

bind tick_timer16 tick_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_in(tick_in), .mode(mode_w), .cnt(cnt_w),
  .term(term_w), .cnt_clr(cnt_clr_w), .step(step_w), .ovf_evt(ovf_evt_w),
  .flag(flag_w), .irq_pend(irq_pend), .irq_req(irq_req)
);

// File: tb/tick_timer16_test.sv
module tick_timer16_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_pend, irq_req;

  int errors = 0;
  int checks = 0;
  logic  rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tick_timer16 uut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_pend(irq_pend), .irq_req(irq_req)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected item for each read the design answered
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(tag_q.pop_front(), int'(reg_rdata), int'(exp_q.pop_front()));
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d, logic tk = 1'b0);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick_in = tk;
    @(negedge clk);
    reg_wr = 1'b0; tick_in = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_pend", int'(irq_pend), 0);
    check("R1 irq_req", int'(irq_req), 0);
    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd1, 8'h00, "R1 cnt lo");
    rd(3'd2, 8'h00, "R1 cnt hi");
    rd(3'd5, 8'h00, "R1 irqcfg");
    // R3 halted after reset
    ticks(5);
    rd(3'd1, 8'h00, "R3 halt at reset");
    // R6 free count, /1
    wr(3'd0, 8'h01);
    ticks(10);
    rd(3'd1, 8'd10, "R6 free count 10");
    // R3 halt keeps value
    wr(3'd0, 8'h00);
    ticks(4);
    rd(3'd1, 8'd10, "R3 halt holds");
    // R9 coherent read
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    ticks(300);
    rd(3'd1, 8'h2C, "R9 lo of 300");
    ticks(300);
    rd(3'd2, 8'h01, "R9 held hi");
    rd(3'd1, 8'h58, "R9 lo of 600");
    rd(3'd2, 8'h02, "R9 hi of 600");
    // R10 low write clears
    wr(3'd1, 8'hA5);
    rd(3'd1, 8'h00, "R10 clear lo");
    rd(3'd2, 8'h00, "R10 clear hi");
    // R4 prescaler ratios
    wr(3'd0, 8'h05); wr(3'd1, 8'h00);
    ticks(20);
    rd(3'd1, 8'd2, "R4 div8");
    wr(3'd0, 8'h09); wr(3'd1, 8'h00);
    ticks(70);
    rd(3'd1, 8'd2, "R4 div32");
    wr(3'd0, 8'h0D); wr(3'd1, 8'h00);
    ticks(300);
    rd(3'd1, 8'd2, "R4 div128");
    rd(3'd0, 8'h0D, "R2 ctrl readback");
    // R5 control write restarts phase
    wr(3'd0, 8'h05); wr(3'd1, 8'h00);
    ticks(5);
    wr(3'd0, 8'h05);
    ticks(5);
    rd(3'd1, 8'd0, "R5 phase restarted");
    ticks(3);
    rd(3'd1, 8'd1, "R5 step after full period");
    // R6 wrap and flag
    wr(3'd0, 8'h01); wr(3'd1, 8'h00);
    ticks(65534);
    rd(3'd1, 8'hFE, "R6 lo before top");
    rd(3'd0, 8'h01, "R6 flag clear before top");
    ticks(1);
    rd(3'd1, 8'hFF, "R6 lo at top");
    rd(3'd2, 8'hFF, "R6 hi at top");
    rd(3'd0, 8'h11, "R6 flag at top");
    check("R12 pend masked", int'(irq_pend), 0);
    wr(3'd5, 8'h01);
    @(negedge clk);
    check("R12 pend", int'(irq_pend), 1);
    check("R12 req needs enable", int'(irq_req), 0);
    wr(3'd5, 8'h03);
    @(negedge clk);
    check("R12 req", int'(irq_req), 1);
    ticks(1);
    rd(3'd1, 8'h00, "R6 wrap lo");
    rd(3'd2, 8'h00, "R6 wrap hi");
    rd(3'd0, 8'h11, "R11 flag sticky");
    // R11 clear and write-1 no effect
    wr(3'd0, 8'h01);
    @(negedge clk);
    check("R11 pend after clear", int'(irq_pend), 0);
    check("R11 req after clear", int'(irq_req), 0);
    wr(3'd0, 8'h11);
    rd(3'd0, 8'h01, "R11 write one ignored");
    // R7 modulo
    wr(3'd3, 8'd5); wr(3'd4, 8'd0);
    rd(3'd3, 8'd5, "R2 term readback");
    wr(3'd0, 8'h02); wr(3'd1, 8'h00);
    ticks(4);
    rd(3'd1, 8'd4, "R7 below term");
    rd(3'd0, 8'h02, "R7 no flag yet");
    ticks(1);
    rd(3'd1, 8'd5, "R7 at term");
    rd(3'd0, 8'h12, "R7 flag at term");
    ticks(1);
    rd(3'd1, 8'd0, "R7 reload");
    ticks(1);
    rd(3'd1, 8'd1, "R7 after reload");
    // R11 set wins over clear
    wr(3'd0, 8'h02); wr(3'd1, 8'h00);
    ticks(4);
    wr(3'd0, 8'h02, 1'b1);
    rd(3'd0, 8'h12, "R11 set beats clear");
    rd(3'd1, 8'd5, "R11 step with ctrl write");
    // R8 up/down
    wr(3'd0, 8'h03); wr(3'd3, 8'd3); wr(3'd1, 8'h00);
    ticks(3);
    rd(3'd1, 8'd3, "R8 top");
    rd(3'd0, 8'h03, "R8 no flag at top");
    ticks(2);
    rd(3'd1, 8'd1, "R8 down");
    ticks(1);
    rd(3'd1, 8'd0, "R8 zero");
    rd(3'd0, 8'h13, "R8 flag at zero");
    ticks(1);
    rd(3'd1, 8'd1, "R8 turns up");
    repeat (3) @(negedge clk);
    check("queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule